// File: doc/BRIEF.md
# Cascadable Prescaled Down-Counter Timer Bank

The block holds a parameterised set of decrementing timers (four by default, 32 bits each) behind one synchronous register port. Each timer owns a period register and a configuration word. The configuration word selects the counting mode, the clock divider, the interrupt shape and an optional cascade source. Software loads a period and starts the timer. The counter then steps down once per count tick. A count tick comes from a per-timer divider, or, in cascade mode, from the terminal event of a lower-numbered timer.

A terminal event happens on a count tick that finds the counter at zero. On that event the timer does one of three things, depending on its mode: it halts (one-shot), it reloads the period (auto-reload) or it wraps to all ones (free-running). The event also raises the timer's interrupt line. That line is either a sticky level that software clears, or a short pulse that ends on its own. Chaining timers multiplies their periods, which gives very long intervals.

The address is `{timer index, register select}`. The register select is 0 for the period, 1 for the configuration, 2 for the command/status word and 3 for the live count. Read data is registered: the value for the address presented before a clock edge appears after that edge.

Top module: `tmr_bank`

## Requirements
- R1: After reset, all interrupt lines are low, every timer is stopped, and its count, period and configuration read as zero.
- R2: In one-shot mode (configuration bits [1:0] = 0), a timer raises one event and then stops with its count at zero. Status bit 0 (running) reads 0 afterwards.
- R3: The divider code in configuration bits [3:2] selects 1, 2, 4 or 16 clock cycles per count tick (codes 0..3). A started timer with period P and divider D raises its event (P+1)*D edges after the start edge.
- R4: In auto-reload mode (bits [1:0] = 1), the counter reloads the period on each event and keeps running, with events every P+1 ticks.
- R5: In free-running mode (bits [1:0] = 2 or 3), the counter reads all ones right after an event and keeps decrementing.
- R6: Writing bit 1 of the command word stops the timer and freezes its count. Writing bit 0 reloads the period, clears the divider phase and starts counting. If both bits are set, start wins.
- R7: The count register returns the live value while running. A read samples the value held before the edge that captures it.
- R8: With interrupt shape 0 (bits [5:4]), the interrupt stays high until a clear (command bit 2) is written in a cycle without a new event.
- R9: Interrupt shape codes 1, 2 and 3 give a pulse of 1, 2 and 4 clock cycles that ends without software action.
- R10: When an event and a clear fall in the same cycle, the interrupt stays asserted.
- R11: With cascade enabled (bit 6) and a source index (bits [11:8]) lower than its own, a timer ticks once per terminal event of the source. It sees each event one cycle after that event is raised.
- R12: A cascade source index not lower than the timer's own index is ignored, and the timer keeps using its divider.
- R13: Status reads return the running flag in bit 0 and the interrupt in bit 1. The configuration reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the addressed register |
| addr | input | 4 | Timer index [3:2], register select [1:0] |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Registered read data for the address seen at the previous edge |
| irq | output | 4 | One interrupt line per timer |

## Verification
A software clear and a new terminal event can land on the same edge. The bench runs an auto-reload timer with its interrupt left high. It times a clear write so that it is sampled on exactly the edge of the next event, then expects the line still high. A clear one cycle later must drop the line. A stop and a pending count tick also coincide. The bench judges this by reading back a count that must equal the value held before the stop edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    MODE_ONCE   = 2'd0,
    MODE_RELOAD = 2'd1,
    MODE_FREE   = 2'd2,
    MODE_FREE2  = 2'd3
  } mode_e;

  // Strobes decoded by control, consumed by each timer datapath
  typedef struct packed {
    logic start;
    logic stop;
    logic clr;
  } strobe_t;

  typedef struct packed {
    logic [3:0] baseSel;
    logic       cascEn;
    logic [1:0] width;
    logic [1:0] div;
    mode_e      mode;
  } cfg_t;

  localparam logic [1:0] REG_PERIOD = 2'd0;
  localparam logic [1:0] REG_CFG    = 2'd1;
  localparam logic [1:0] REG_CTRL   = 2'd2;
  localparam logic [1:0] REG_COUNT  = 2'd3;

  localparam int CMD_START = 0;
  localparam int CMD_STOP  = 1;
  localparam int CMD_CLR   = 2;

endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int N_TMR  = 4,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic [CNT_W-1:0]  countIn [N_TMR],
  input  logic [N_TMR-1:0]  runIn,
  input  logic [N_TMR-1:0]  irqIn,
  output logic [CNT_W-1:0]  periodQ [N_TMR],
  output cfg_t              cfgQ    [N_TMR],
  output strobe_t           strb    [N_TMR],
  output logic [CNT_W-1:0]  rdData
);

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic [1:0]       sel;
  logic [CNT_W-1:0] rdNext;
  logic             unusedWr;

  assign idx      = addr[ADDR_W-1:2];
  assign sel      = addr[1:0];
  assign unusedWr = ^{wrData[CNT_W-1:12], wrData[7]};

  for (genvar i = 0; i < N_TMR; i++) begin : g_reg
    logic hitMe;
    assign hitMe = wrEn && (idx == IDX_W'(i));

    assign strb[i].start = hitMe && (sel == REG_CTRL) && wrData[CMD_START];
    assign strb[i].stop  = hitMe && (sel == REG_CTRL) && wrData[CMD_STOP];
    assign strb[i].clr   = hitMe && (sel == REG_CTRL) && wrData[CMD_CLR];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        periodQ[i] <= '0;
        cfgQ[i]    <= '0;
      end else if (hitMe && sel == REG_PERIOD) begin
        periodQ[i] <= wrData;
      end else if (hitMe && sel == REG_CFG) begin
        cfgQ[i].mode    <= mode_e'(wrData[1:0]);
        cfgQ[i].div     <= wrData[3:2];
        cfgQ[i].width   <= wrData[5:4];
        cfgQ[i].cascEn  <= wrData[6];
        cfgQ[i].baseSel <= wrData[11:8];
      end
    end
  end

  always_comb begin
    rdNext = '0;
    unique case (sel)
      REG_PERIOD: rdNext = periodQ[idx];
      REG_CFG: begin
        rdNext[1:0]  = cfgQ[idx].mode;
        rdNext[3:2]  = cfgQ[idx].div;
        rdNext[5:4]  = cfgQ[idx].width;
        rdNext[6]    = cfgQ[idx].cascEn;
        rdNext[11:8] = cfgQ[idx].baseSel;
      end
      REG_CTRL: begin
        rdNext[0] = runIn[idx];
        rdNext[1] = irqIn[idx];
      end
      default: rdNext = countIn[idx];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else       rdData <= rdNext;
  end

endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PRE_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  cfg_t             cfg,
  input  logic [CNT_W-1:0] period,
  input  logic             useExt,
  input  logic             extTick,
  output logic [CNT_W-1:0] count,
  output logic             running,
  output logic             irq,
  output logic             evt
);

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preMax;
  logic [1:0]       pulseLeft;
  logic             tick;
  logic             hit;
  logic             levelMode;
  logic             unusedCfg;

  assign unusedCfg = ^{cfg.baseSel, cfg.cascEn};

  always_comb begin
    unique case (cfg.div)
      2'd0:    preMax = PRE_W'(0);
      2'd1:    preMax = PRE_W'(1);
      2'd2:    preMax = PRE_W'(3);
      default: preMax = PRE_W'(15);
    endcase
  end

  assign tick      = running && (useExt ? extTick : (preCnt == preMax));
  assign hit       = tick && (count == '0) && !strb.start && !strb.stop;
  assign levelMode = (cfg.width == 2'd0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      count   <= '0;
      preCnt  <= '0;
    end else if (strb.start) begin
      running <= 1'b1;
      count   <= period;
      preCnt  <= '0;
    end else if (strb.stop) begin
      running <= 1'b0;
    end else if (running) begin
      preCnt <= (preCnt == preMax) ? '0 : preCnt + 1'b1;
      if (tick) begin
        if (count == '0) begin
          unique case (cfg.mode)
            MODE_ONCE:   running <= 1'b0;
            MODE_RELOAD: count   <= period;
            default:     count   <= '1;
          endcase
        end else begin
          count <= count - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) evt <= 1'b0;
    else       evt <= hit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irq       <= 1'b0;
      pulseLeft <= '0;
    end else if (hit) begin
      irq       <= 1'b1;
      pulseLeft <= (cfg.width == 2'd3) ? 2'd3 : (cfg.width == 2'd2) ? 2'd1 : 2'd0;
    end else if (strb.clr) begin
      irq <= 1'b0;
    end else if (irq && !levelMode) begin
      if (pulseLeft == 2'd0) irq <= 1'b0;
      else                   pulseLeft <= pulseLeft - 1'b1;
    end
  end

  AST_ONESHOT_HALTS: assert property (@(posedge clk) disable iff (!rstN)
    (hit && cfg.mode == MODE_ONCE) |=> !running); // R2
  AST_AUTO_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    (hit && cfg.mode == MODE_RELOAD) |=> (count == $past(period) && running)); // R4
  AST_FREE_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (hit && cfg.mode[1]) |=> (count == '1)); // R5
  AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !strb.start) |=> $stable(count)); // R6
  AST_START_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.start |=> (running && count == $past(period))); // R6
  AST_LEVEL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (irq && levelMode && !strb.clr) |=> irq); // R8
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rstN)
    hit |=> (irq && evt)); // R10

endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int N_TMR = 4,
  parameter int CNT_W = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      wrEn,
  input  logic [$clog2(N_TMR)+1:0]  addr,
  input  logic [CNT_W-1:0]          wrData,
  output logic [CNT_W-1:0]          rdData,
  output logic [N_TMR-1:0]          irq
);

  localparam int IDX_W  = $clog2(N_TMR);
  localparam int ADDR_W = IDX_W + 2;

  logic [CNT_W-1:0] periodQ [N_TMR];
  logic [CNT_W-1:0] countQ  [N_TMR];
  cfg_t             cfgQ    [N_TMR];
  strobe_t          strb    [N_TMR];
  logic [N_TMR-1:0] runQ;
  logic [N_TMR-1:0] evtQ;
  logic [N_TMR-1:0] useExt;
  logic [N_TMR-1:0] extTick;

  tmr_ctrl #(.N_TMR(N_TMR), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .addr    (addr),
    .wrData  (wrData),
    .countIn (countQ),
    .runIn   (runQ),
    .irqIn   (irq),
    .periodQ (periodQ),
    .cfgQ    (cfgQ),
    .strb    (strb),
    .rdData  (rdData)
  );

  for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
    if (i == 0) begin : g_root
      assign useExt[i]  = 1'b0;
      assign extTick[i] = 1'b0;
    end else begin : g_chain
      assign useExt[i]  = cfgQ[i].cascEn && (cfgQ[i].baseSel < 4'(i));
      assign extTick[i] = evtQ[cfgQ[i].baseSel[IDX_W-1:0]];
    end

    tmr_unit #(.CNT_W(CNT_W)) u_unit (
      .clk     (clk),
      .rstN    (rstN),
      .strb    (strb[i]),
      .cfg     (cfgQ[i]),
      .period  (periodQ[i]),
      .useExt  (useExt[i]),
      .extTick (extTick[i]),
      .count   (countQ[i]),
      .running (runQ[i]),
      .irq     (irq[i]),
      .evt     (evtQ[i])
    );
  end

endmodule

// File: tb/tmr_bank_tb.sv
`timescale 1ns/1ps
module tmr_bank_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [3:0]  irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tmr_bank u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  typedef struct packed {
    logic [15:0] per;
    logic [1:0]  div;
    logic [1:0]  wid;
    logic [15:0] expRise;
    logic [7:0]  expHigh;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{per:16'd5, div:2'd0, wid:2'd1, expRise:16'd6,  expHigh:8'd1},
    '{per:16'd5, div:2'd1, wid:2'd2, expRise:16'd12, expHigh:8'd2},
    '{per:16'd3, div:2'd2, wid:2'd3, expRise:16'd16, expHigh:8'd4},
    '{per:16'd2, div:2'd3, wid:2'd1, expRise:16'd48, expHigh:8'd1},
    '{per:16'd0, div:2'd0, wid:2'd2, expRise:16'd1,  expHigh:8'd2},
    '{per:16'd7, div:2'd1, wid:2'd3, expRise:16'd16, expHigh:8'd4}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int t, input logic [1:0] r, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = {t[1:0], r}; wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic rd(input int t, input logic [1:0] r, output logic [31:0] v);
    @(negedge clk);
    wrEn = 1'b0; addr = {t[1:0], r};
    @(posedge clk); #1;
    v = rdData;
  endtask

  task automatic waitIrq(input int t, output int n);
    n = 0;
    do begin
      @(posedge clk); #1; n++;
    end while (!irq[t] && n < 5000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, a, b;
    int n, h;
    repeat (5) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    #1;
    chk("R1 irq", {28'd0, irq}, 32'd0);
    rd(0, 2'd3, v); chk("R1 count", v, 0);
    rd(1, 2'd2, v); chk("R1 status", v, 0);
    rd(2, 2'd1, v); chk("R1 cfg", v, 0);

    // table walk: one-shot on timer 2, R2 R3 R9
    for (int k = 0; k < 6; k++) begin
      wr(2, 2'd1, {26'd0, VECS[k].wid, VECS[k].div, 2'b00});
      wr(2, 2'd0, {16'd0, VECS[k].per});
      wr(2, 2'd2, 32'h1);
      waitIrq(2, n);
      chk("R3 event edge", n, VECS[k].expRise);
      h = 0;
      while (irq[2] && h < 100) begin @(posedge clk); #1; h++; end
      chk("R9 pulse width", h, VECS[k].expHigh);
      rd(2, 2'd2, v); chk("R2 stopped", v, 0);
      rd(2, 2'd3, v); chk("R2 count zero", v, 0);
    end

    // level interrupt, auto-reload, event vs clear on timer 0
    wr(0, 2'd1, 32'h1);
    wr(0, 2'd0, 32'd4);
    wr(0, 2'd2, 32'h1);                         // start edge E0
    repeat (5) @(posedge clk); #1;             // E5
    chk("R4 first event", irq[0], 1);
    repeat (3) @(posedge clk); #1;             // E8
    chk("R8 held", irq[0], 1);
    @(posedge clk); #1;                        // E9
    wr(0, 2'd2, 32'h4);                        // clear sampled at E10 = event
    chk("R10 event beats clear", irq[0], 1);
    wr(0, 2'd2, 32'h4);                        // clear at E11
    chk("R8 clear drops", irq[0], 0);
    repeat (4) @(posedge clk); #1;             // E15
    chk("R4 reload event", irq[0], 1);
    rd(0, 2'd2, v); chk("R13 status", v, 32'h3);
    wr(0, 2'd2, 32'h6);                        // stop and clear

    // live read, stop freeze, restart on timer 1
    wr(1, 2'd1, 32'h0);
    wr(1, 2'd0, 32'd100);
    wr(1, 2'd2, 32'h1);                        // E0
    rd(1, 2'd3, a);                            // E1
    rd(1, 2'd3, b);                            // E2
    chk("R7 live a", a, 100);
    chk("R7 live b", b, 99);
    wr(1, 2'd2, 32'h2);                        // stop at E3
    repeat (5) @(posedge clk);
    rd(1, 2'd3, v); chk("R6 frozen", v, 98);
    wr(1, 2'd2, 32'h3);                        // start and stop together
    rd(1, 2'd3, v); chk("R6 restart reload", v, 100);
    rd(1, 2'd2, v); chk("R6 start wins", v, 32'h1);
    wr(1, 2'd2, 32'h2);

    // free running on timer 3
    wr(3, 2'd1, 32'h12);
    wr(3, 2'd0, 32'd3);
    wr(3, 2'd2, 32'h1);
    waitIrq(3, n);
    chk("R5 event edge", n, 4);
    wr(3, 2'd2, 32'h2);
    rd(3, 2'd3, v); chk("R5 wrap", v, 32'hFFFF_FFFF);

    // cascade: timer 1 counts timer 0 events
    wr(1, 2'd1, 32'h50);
    rd(1, 2'd1, v); chk("R13 cfg readback", v, 32'h50);
    wr(1, 2'd0, 32'd2);
    wr(1, 2'd2, 32'h1);
    wr(0, 2'd1, 32'h11);
    wr(0, 2'd0, 32'd3);
    wr(0, 2'd2, 32'h1);                        // E0 of base
    waitIrq(1, n);
    chk("R11 cascade edge", n, 13);
    wr(0, 2'd2, 32'h2);
    wr(1, 2'd2, 32'h2);

    // illegal cascade source: timer 1 naming itself
    wr(1, 2'd1, 32'h150);
    wr(1, 2'd0, 32'd5);
    wr(1, 2'd2, 32'h1);
    waitIrq(1, n);
    chk("R12 divider used", n, 6);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule